// File: doc/BRIEF.md
# Two-Rank Ripple Gray Counter

This block counts rising edges of its input clock and presents the count as a 7-bit reflected Gray code. It is built from two ranks of positive-edge toggle flip-flops. The first rank is an asynchronous ripple binary counter. Only the least significant stage sees the input clock; every later stage is clocked by the inverted output of the stage below it.

The second rank holds one toggle flip-flop for each first-rank bit except the top one. Each of these flip-flops is clocked by its own binary bit, so it flips every time that bit rises. The Gray word takes its top bit straight from the binary MSB and its lower bits from the second rank. No XOR gates sit in the output path, and there is no feedback from MSB to LSB.

An active-low asynchronous reset clears every flip-flop in both ranks and overrides the clock for as long as it is held. The binary value is also brought out so that it can be observed. Outputs are only meaningful once the ripple through the stages has settled after each clock edge.

Top module: `gray_ripple_counter`

## Requirements
- R1: While rst_ni is low, gray_o and bin_o both read 0000000, whatever clk_i does.
- R2: After rst_ni is released, each rising edge of clk_i increases bin_o by one, modulo 128.
- R3: bin_o[0] toggles on every rising edge of clk_i. bin_o[i+1] changes only in an update where bin_o[i] falls from 1 to 0.
- R4: gray_o[6] always equals bin_o[6].
- R5: For i from 0 to 5, gray_o[i] toggles on each rising edge of bin_o[i], so that gray_o[i] equals bin_o[i] XOR bin_o[i+1].
- R6: After reset the settled gray_o sequence is 0000000, 0000001, 0000011, 0000010, 0000110 and so on, which is the reflected Gray code of the edge count. Count 8 reads 0001100, count 63 reads 0100000, count 64 reads 1100000 and count 127 reads 1000000.
- R7: Each counted edge changes exactly one bit of gray_o. This includes the wrap from 1000000 to 0000000 on the 128th edge.
- R8: Pulling rst_ni low in the middle of a count clears both outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Count clock; rising edges are counted |
| rst_ni | input | 1 | Active-low asynchronous clear of both ranks |
| gray_o | output | 7 | Settled Gray-coded count |
| bin_o | output | 7 | First-rank binary ripple value |

## Verification
On every clock edge after the first one out of reset, the assertions check four things:
- the binary value went up by one;
- each higher binary bit changed only when the bit below it fell;
- the Gray word matches the binary value;
- exactly one Gray bit changed.

They also check that both outputs read zero at any clock edge taken while reset is held. The bench alone shows the clear landing between clock edges as soon as reset falls, and the exact Gray values against known code words, including the wrap at 128.

// File: rtl/gray_ripple_pkg.sv
package gray_ripple_pkg;
  localparam int unsigned CNT_W = 7;

  function automatic logic [CNT_W-1:0] bin_to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/toggle_ff.sv
module toggle_ff (
  input  logic clk_i,
  input  logic rst_ni,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= ~q_q;
  end

  assign q_o = q_q;
endmodule

// File: rtl/ripple_rank.sv
module ripple_rank #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] bin_o
);
  logic [WIDTH-1:0] stage_clk;
  logic [WIDTH-1:0] stage_q;

  assign stage_clk[0] = clk_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i > 0) begin : g_chain
      // rising edge of inverted lower bit == falling edge of that bit
      assign stage_clk[i] = ~stage_q[i-1];
    end
    toggle_ff u_ff (
      .clk_i (stage_clk[i]),
      .rst_ni(rst_ni),
      .q_o   (stage_q[i])
    );
  end

  assign bin_o = stage_q;

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar i = 0; i + 1 < WIDTH; i++) begin : g_chk
    p_carry_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && (stage_q[i+1] != $past(stage_q[i+1]))) |-> ($past(stage_q[i]) && !stage_q[i]))
      else $error("R3: stage %0d moved without a fall below it", i + 1);
  end

  p_lsb_toggles_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (stage_q[0] != $past(stage_q[0])))
    else $error("R3: stage 0 did not toggle");
endmodule

// File: rtl/gray_rank.sv
module gray_rank #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] bin_i,
  output logic [WIDTH-1:0] gray_o
);
  logic [WIDTH-2:0] low_q;

  for (genvar i = 0; i < WIDTH - 1; i++) begin : g_low
    toggle_ff u_ff (
      .clk_i (bin_i[i]),
      .rst_ni(rst_ni),
      .q_o   (low_q[i])
    );
  end

  assign gray_o = {bin_i[WIDTH-1], low_q};
endmodule

// File: rtl/gray_ripple_counter.sv
module gray_ripple_counter
  import gray_ripple_pkg::*;
#(
  parameter int unsigned WIDTH = CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] gray_o,
  output logic [WIDTH-1:0] bin_o
);
  logic [WIDTH-1:0] bin_w;
  logic [WIDTH-1:0] gray_w;

  ripple_rank #(.WIDTH(WIDTH)) u_ripple (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bin_o (bin_w)
  );

  gray_rank #(.WIDTH(WIDTH)) u_gray (
    .rst_ni(rst_ni),
    .bin_i (bin_w),
    .gray_o(gray_w)
  );

  assign bin_o  = bin_w;
  assign gray_o = gray_w;

  // one counted edge seen since reset release
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (gray_o == '0 && bin_o == '0))
    else $error("R1: outputs not clear under reset");

  p_count_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (bin_o == WIDTH'($past(bin_o) + 1'b1)))
    else $error("R2: binary did not advance by one");

  p_gray_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gray_o == bin_to_gray(bin_o))
    else $error("R5: second rank out of step with first rank");

  p_one_bit_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ($countones(gray_o ^ $past(gray_o)) == 1))
    else $error("R7: Gray step not single-bit");
endmodule

// File: tb/gray_ripple_counter_tb_top.sv
`timescale 1ns/1ps
module gray_ripple_counter_tb_top;
  localparam int W = 7;
  localparam int NV = 8;
  // edges to apply, then expected settled Gray word (R6)
  localparam int          STEPS [NV] = '{1, 1, 1, 1, 4, 8, 47, 1};
  localparam logic [W-1:0] GOLD [NV] = '{7'h01, 7'h03, 7'h02, 7'h06,
                                        7'h0C, 7'h18, 7'h20, 7'h60};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic [W-1:0] gray_o, bin_o;
  logic [W-1:0] ref_cnt = '0;
  logic [W-1:0] prev_gray;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gray_ripple_counter dut_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .gray_o(gray_o),
    .bin_o (bin_o)
  );

  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    ref_cnt = ref_cnt + 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 gray under reset", gray_o, '0);
    check("R1 bin under reset", bin_o, '0);
    rst_ni = 1'b1;
    ref_cnt = '0;
    #1 check("R6 gray after release", gray_o, '0);

    for (int v = 0; v < NV; v++) begin
      for (int s = 0; s < STEPS[v]; s++) step();
      check("R6 gray table", gray_o, GOLD[v]);
      check("R2 bin table", bin_o, ref_cnt);
    end

    // sweep 64..127 and wrap to 0
    for (int k = 0; k < 64; k++) begin
      prev_gray = gray_o;
      step();
      check("R5 gray vs ref", gray_o, to_gray(ref_cnt));
      check("R2 bin vs ref", bin_o, ref_cnt);
      check("R4 gray msb", {6'd0, gray_o[W-1]}, {6'd0, bin_o[W-1]});
      check("R7 one bit", W'($countones(gray_o ^ prev_gray)), W'(1));
      if (ref_cnt == 7'd127) check("R6 count 127", gray_o, 7'h40);
    end
    check("R7 wrap to zero", gray_o, '0);
    check("R3 bin wrap", bin_o, '0);

    // async clear mid-count
    repeat (5) step();
    check("R6 count 5", gray_o, 7'h07);
    rst_ni = 1'b0;
    #1;
    check("R8 gray cleared without edge", gray_o, '0);
    check("R8 bin cleared without edge", bin_o, '0);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 reset overrides clock", gray_o, '0);
    rst_ni = 1'b1;
    ref_cnt = '0;
    step();
    check("R6 first after re-release", gray_o, 7'h01);
    check("R3 lsb first edge", bin_o, 7'h01);
    finish_run();
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end
endmodule